// File: doc/BRIEF.md
# Load-to-Store Write-Data Forwarding Unit

This block sits in the memory access stage of an in-order pipeline. It selects the word driven onto the data memory write-data port. In a memory-to-memory copy, a load is followed at once by a store of the loaded register. When the store reaches the memory stage, the loaded value has only just reached the write-back pipeline register. The register file has not yet been written, so the store data carried down the pipeline is stale. Without this block, the pipeline would have to stall the pair for a cycle.

A small control part compares the store's data source register with the destination of the instruction one stage ahead. It also checks that the instruction ahead really is a register-writing load. When every condition holds, it raises a one-bit select. The datapath part then drives the loaded word from the write-back register onto the memory write-data port. Otherwise the datapath passes the store data carried in the memory-stage pipeline register. The whole unit is combinational, so the selected word is valid in the same cycle as its inputs.

Top module: `lsf_forward_unit`

## Requirements
- R1: When the memory-stage instruction writes memory, and the write-back instruction writes a register with a value loaded from memory, and that register is nonzero and equals the store's data source register, then fwdSel is 1 and memWriteData equals wbLoadData.
- R2: When memMemWrite is 0, fwdSel is 0, whatever the other inputs are.
- R3: When wbRegWrite is 0, fwdSel is 0.
- R4: When wbMemToReg is 0 (the write-back value comes from the ALU, not from memory), fwdSel is 0.
- R5: When wbDestReg is register number 0, fwdSel is 0, even if the store's source register is also 0.
- R6: When wbDestReg differs from memStoreSrcReg, fwdSel is 0.
- R7: Whenever fwdSel is 0, memWriteData equals memStoreData.
- R8: The unit holds no state. A change of any input shows on fwdSel and memWriteData within the same clock cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wbDestReg | input | REG_W | Destination register number held in the write-back pipeline register |
| wbRegWrite | input | 1 | Write-back instruction writes the register file |
| wbMemToReg | input | 1 | Write-back value comes from data memory (the instruction is a load) |
| wbLoadData | input | DATA_W | Loaded word held in the write-back pipeline register |
| memStoreSrcReg | input | REG_W | Register number that supplies the memory-stage store's data |
| memMemWrite | input | 1 | Memory-stage instruction writes data memory |
| memStoreData | input | DATA_W | Store data carried in the memory-stage pipeline register |
| memWriteData | output | DATA_W | Word driven to the data memory write-data port |
| fwdSel | output | 1 | 1 when the loaded word is forwarded to the write-data port |

## Verification
The bench uses a small configuration with eight registers. It sweeps every combination of the three control flags, every destination register number and every source register number. Matched and mismatched register pairs therefore meet each flag pattern, including the register-0 case. Each case is tagged with the first condition that blocks forwarding, so a failure shows which guard was lost. The loaded word and the carried store data always differ in every bit, so a wrong select shows directly on the data output. A separate step changes the inputs between clock edges, which catches any registered path.

// File: rtl/lsf_pkg.sv
package lsf_pkg;

  // Strobes passed from the select control to the write-data datapath
  typedef struct packed {
    logic takeLoad;   // drive the write-back loaded word
    logic regMatch;   // source register equals load destination (nonzero)
  } fwdStrobe_t;

endpackage

// File: rtl/lsf_ctrl.sv
module lsf_ctrl
  import lsf_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] wbDestReg,
  input  logic             wbRegWrite,
  input  logic             wbMemToReg,
  input  logic [REG_W-1:0] memStoreSrcReg,
  input  logic             memMemWrite,
  output fwdStrobe_t       strobe
);

  localparam logic [REG_W-1:0] ZeroReg = '0;

  logic destLive;
  logic isLoadWrite;

  always_comb begin
    destLive        = (wbDestReg != ZeroReg);
    isLoadWrite     = wbRegWrite & wbMemToReg;
    strobe.regMatch = destLive & (wbDestReg == memStoreSrcReg);
    strobe.takeLoad = memMemWrite & isLoadWrite & strobe.regMatch;
  end

  always_comb begin
    // R2
    sel_needs_store_chk: assert (!strobe.takeLoad || memMemWrite);
    // R3
    sel_needs_regwrite_chk: assert (!strobe.takeLoad || wbRegWrite);
    // R4
    sel_needs_load_chk: assert (!strobe.takeLoad || wbMemToReg);
    // R5
    sel_not_reg0_chk: assert (!strobe.takeLoad || wbDestReg != ZeroReg);
    // R6
    sel_reg_match_chk: assert (!strobe.takeLoad || wbDestReg == memStoreSrcReg);
  end

endmodule

// File: rtl/lsf_datapath.sv
module lsf_datapath
  import lsf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  fwdStrobe_t        strobe,
  input  logic [DATA_W-1:0] wbLoadData,
  input  logic [DATA_W-1:0] memStoreData,
  output logic [DATA_W-1:0] memWriteData
);

  always_comb begin
    if (strobe.takeLoad) memWriteData = wbLoadData;
    else                 memWriteData = memStoreData;
  end

endmodule

// File: rtl/lsf_forward_unit.sv
module lsf_forward_unit
  import lsf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_W  = 5
) (
  input  logic [REG_W-1:0]  wbDestReg,
  input  logic              wbRegWrite,
  input  logic              wbMemToReg,
  input  logic [DATA_W-1:0] wbLoadData,
  input  logic [REG_W-1:0]  memStoreSrcReg,
  input  logic              memMemWrite,
  input  logic [DATA_W-1:0] memStoreData,
  output logic [DATA_W-1:0] memWriteData,
  output logic              fwdSel
);

  fwdStrobe_t strobe;

  lsf_ctrl #(.REG_W(REG_W)) u_ctrl (
    .wbDestReg      (wbDestReg),
    .wbRegWrite     (wbRegWrite),
    .wbMemToReg     (wbMemToReg),
    .memStoreSrcReg (memStoreSrcReg),
    .memMemWrite    (memMemWrite),
    .strobe         (strobe)
  );

  lsf_datapath #(.DATA_W(DATA_W)) u_dp (
    .strobe       (strobe),
    .wbLoadData   (wbLoadData),
    .memStoreData (memStoreData),
    .memWriteData (memWriteData)
  );

  assign fwdSel = strobe.takeLoad;

  always_comb begin
    // R1
    fwd_load_data_chk: assert (!fwdSel || memWriteData == wbLoadData);
    // R7
    pass_store_data_chk: assert (fwdSel || memWriteData == memStoreData);
  end

endmodule

// File: tb/sim_lsf_forward_unit.sv
module sim_lsf_forward_unit;

  localparam int DW = 8;
  localparam int RW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic [RW-1:0] wbDestReg, memStoreSrcReg;
  logic          wbRegWrite, wbMemToReg, memMemWrite;
  logic [DW-1:0] wbLoadData, memStoreData, memWriteData;
  logic          fwdSel;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  lsf_forward_unit #(.DATA_W(DW), .REG_W(RW)) u0 (
    .wbDestReg      (wbDestReg),
    .wbRegWrite     (wbRegWrite),
    .wbMemToReg     (wbMemToReg),
    .wbLoadData     (wbLoadData),
    .memStoreSrcReg (memStoreSrcReg),
    .memMemWrite    (memMemWrite),
    .memStoreData   (memStoreData),
    .memWriteData   (memWriteData),
    .fwdSel         (fwdSel)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic string blockTag(input logic mw, input logic rw, input logic m2r,
                                     input logic [RW-1:0] d, input logic [RW-1:0] s);
    if (!mw)      return "R2";
    if (!rw)      return "R3";
    if (!m2r)     return "R4";
    if (d == 0)   return "R5";
    if (d != s)   return "R6";
    return "R1";
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected below 20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    wbDestReg = '0; memStoreSrcReg = '0;
    wbRegWrite = 1'b0; wbMemToReg = 1'b0; memMemWrite = 1'b0;
    wbLoadData = 8'h3C; memStoreData = 8'hC3;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    // R7 idle state: nothing forwarded
    chk("R7 idle sel", {7'b0, fwdSel}, 8'h00);
    chk("R7 idle data", memWriteData, 8'hC3);

    // Exhaustive sweep over flags and register pairs
    for (int f = 0; f < 8; f++) begin
      for (int d = 0; d < 8; d++) begin
        for (int s = 0; s < 8; s++) begin
          logic expSel;
          logic [DW-1:0] ld, st;
          string tag;
          @(negedge clk);
          memMemWrite    = f[0];
          wbRegWrite     = f[1];
          wbMemToReg     = f[2];
          wbDestReg      = d[RW-1:0];
          memStoreSrcReg = s[RW-1:0];
          ld = 8'(f * 64 + d * 8 + s) ^ 8'hA5;
          st = ~ld;
          wbLoadData   = ld;
          memStoreData = st;
          #1;
          tag = blockTag(f[0], f[1], f[2], d[RW-1:0], s[RW-1:0]);
          expSel = (tag == "R1");
          chk({tag, " sel"}, {7'b0, fwdSel}, {7'b0, expSel});
          chk(expSel ? "R1 data" : "R7 data", memWriteData, expSel ? ld : st);
        end
      end
    end

    // R8: mid-cycle input changes show without a clock edge
    @(negedge clk);
    memMemWrite = 1'b1; wbRegWrite = 1'b1; wbMemToReg = 1'b1;
    wbDestReg = 3'd5; memStoreSrcReg = 3'd5;
    wbLoadData = 8'h11; memStoreData = 8'hEE;
    #0.5;
    chk("R8 fwd same cycle", memWriteData, 8'h11);
    memStoreSrcReg = 3'd4;
    #0.5;
    chk("R8 drop same cycle", memWriteData, 8'hEE);
    wbLoadData = 8'h22; memStoreSrcReg = 3'd5;
    #0.5;
    chk("R8 new load same cycle", memWriteData, 8'h22);

    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule